// File: doc/BRIEF.md
# Inbound Packet Port Router

This block sits between the receive buffer and the user-facing streams of a packet endpoint. Each received logical-layer packet arrives as a stream of 64-bit beats, and the last beat is marked. The block reads the 4-bit format type from the header in the first beat and picks one destination for the whole packet. The destinations are a general I/O stream, a messaging stream, a maintenance stream and a user-defined stream.

Two static configuration inputs shape the routing. `msg_split_i` gives messages their own stream instead of sharing the I/O stream. `usr_en_i` says whether the user-defined stream exists. A packet that has no destination is consumed at full rate and thrown away. Each drop sets a sticky decode-error flag. The flag stays high until the first beat of a packet that does have a destination is accepted.

The router is a pure steering stage and adds no latency. Valid, data and last pass combinationally to the selected output. The selected output's ready passes back to the input.

Top module: `inb_port_router`

## Requirements
- R1: A packet whose first-beat format type (bits [55:52]) is 2, 5, 6 or 13 is presented on the I/O output only.
- R2: A packet with format type 10 is presented on the I/O output only, whatever the value of `msg_split_i`.
- R3: A packet with format type 11 is presented on the messaging output when `msg_split_i` is 1, and on the I/O output when it is 0.
- R4: A packet with format type 8 is presented on the maintenance output only. At most one output is valid in any cycle.
- R5: A packet with any other format type (0, 1, 3, 4, 7, 9, 12, 14, 15) is presented on the user-defined output when `usr_en_i` is 1.
- R6: When `usr_en_i` is 0, a packet of an R5 type appears on no output. `s_ready_o` is 1 for every one of its beats, whatever the output readies are.
- R7: `decode_err_o` goes to 1 in the cycle after the first beat of a dropped packet is accepted. It stays 1 through idle cycles and further drops. It returns to 0 in the cycle after the first beat of a routed packet is accepted.
- R8: Beats after the first, up to and including the one with last set, go to the output chosen at the first beat. Their own format-type bits and any change of the configuration inputs do not affect this.
- R9: While a packet is routed, `s_ready_o` equals the ready of the selected output. Data and last reach that output unchanged.
- R10: After reset no packet is in progress, no output is valid while the input is idle, and `decode_err_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Logical-layer clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| msg_split_i | input | 1 | 1: messages use the messaging output |
| usr_en_i | input | 1 | 1: user-defined output present |
| s_valid_i | input | 1 | Inbound beat valid |
| s_ready_o | output | 1 | Inbound beat accepted |
| s_data_i | input | DATA_W | Inbound beat data; header on first beat |
| s_last_i | input | 1 | Final beat of packet |
| io_valid_o | output | 1 | I/O output valid |
| io_ready_i | input | 1 | I/O output ready |
| io_data_o | output | DATA_W | I/O output data |
| io_last_o | output | 1 | I/O output last |
| msg_valid_o | output | 1 | Messaging output valid |
| msg_ready_i | input | 1 | Messaging output ready |
| msg_data_o | output | DATA_W | Messaging output data |
| msg_last_o | output | 1 | Messaging output last |
| mnt_valid_o | output | 1 | Maintenance output valid |
| mnt_ready_i | input | 1 | Maintenance output ready |
| mnt_data_o | output | DATA_W | Maintenance output data |
| mnt_last_o | output | 1 | Maintenance output last |
| usr_valid_o | output | 1 | User-defined output valid |
| usr_ready_i | input | 1 | User-defined output ready |
| usr_data_o | output | DATA_W | User-defined output data |
| usr_last_o | output | 1 | User-defined output last |
| decode_err_o | output | 1 | Sticky flag: a packet was discarded |

## Verification
The assertions check every cycle that at most one output is valid and that a packet in progress stays on its output. They also check that a drop is taken at full rate, that the flag follows each first-beat acceptance, and that messages and maintenance packets take their fixed outputs. Only the bench scenarios can show the full routing table. The bench sweeps all sixteen format types under all four configurations, then flips the configuration in mid-packet and stalls each destination. It also shows that the flag survives idle gaps and is cleared by the next routed packet.

// File: rtl/ipr_pkg.sv
package ipr_pkg;
  localparam int unsigned NUM_DST = 4;
  localparam int unsigned FT_W    = 4;

  typedef enum logic [2:0] {
    DST_IO   = 3'd0,
    DST_MSG  = 3'd1,
    DST_MNT  = 3'd2,
    DST_USR  = 3'd3,
    DST_DROP = 3'd4
  } dst_e;

  localparam logic [FT_W-1:0] FT_RD   = 4'd2;
  localparam logic [FT_W-1:0] FT_WR   = 4'd5;
  localparam logic [FT_W-1:0] FT_SWR  = 4'd6;
  localparam logic [FT_W-1:0] FT_MNT  = 4'd8;
  localparam logic [FT_W-1:0] FT_DBL  = 4'd10;
  localparam logic [FT_W-1:0] FT_MSG  = 4'd11;
  localparam logic [FT_W-1:0] FT_RSP  = 4'd13;
endpackage

// File: rtl/ipr_classify.sv
module ipr_classify
  import ipr_pkg::*;
(
  input  logic [FT_W-1:0] ftype_i,
  input  logic            msg_split_i,
  input  logic            usr_en_i,
  output dst_e            dst_o
);
  always_comb begin
    unique case (ftype_i)
      FT_RD, FT_WR, FT_SWR, FT_RSP, FT_DBL: dst_o = DST_IO;
      FT_MSG:  dst_o = msg_split_i ? DST_MSG : DST_IO;
      FT_MNT:  dst_o = DST_MNT;
      default: dst_o = usr_en_i ? DST_USR : DST_DROP;
    endcase
  end
endmodule

// File: rtl/ipr_track.sv
module ipr_track
  import ipr_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic fire_i,
  input  logic last_i,
  input  dst_e dst_i,
  output dst_e dst_o,
  output logic mid_o
);
  logic mid_q;
  dst_e held_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      mid_q  <= 1'b0;
      held_q <= DST_DROP;
    end else if (fire_i) begin
      if (last_i) begin
        mid_q <= 1'b0;
      end else if (!mid_q) begin
        mid_q  <= 1'b1;
        held_q <= dst_i;
      end
    end
  end

  // first beat decides; later beats reuse the latched choice
  assign dst_o = mid_q ? held_q : dst_i;
  assign mid_o = mid_q;
endmodule

// File: rtl/ipr_steer.sv
module ipr_steer
  import ipr_pkg::*;
#(
  parameter int unsigned N = NUM_DST
) (
  input  logic         in_valid_i,
  input  dst_e         sel_i,
  input  logic [N-1:0] out_ready_i,
  output logic [N-1:0] out_valid_o,
  output logic         in_ready_o
);
  for (genvar k = 0; k < N; k++) begin : g_out
    assign out_valid_o[k] = in_valid_i && (sel_i == dst_e'(k));
  end

  always_comb begin
    in_ready_o = (sel_i == DST_DROP);
    for (int k = 0; k < int'(N); k++) begin
      if (sel_i == dst_e'(k)) in_ready_o = out_ready_i[k];
    end
  end
endmodule

// File: rtl/ipr_err_flag.sv
module ipr_err_flag (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic first_fire_i,
  input  logic dropped_i,
  output logic err_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           err_o <= 1'b0;
    else if (first_fire_i) err_o <= dropped_i;
  end
endmodule

// File: rtl/inb_port_router.sv
module inb_port_router
  import ipr_pkg::*;
#(
  parameter int unsigned DATA_W = 64,
  parameter int unsigned FT_LSB = 52
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              msg_split_i,
  input  logic              usr_en_i,
  input  logic              s_valid_i,
  output logic              s_ready_o,
  input  logic [DATA_W-1:0] s_data_i,
  input  logic              s_last_i,
  output logic              io_valid_o,
  input  logic              io_ready_i,
  output logic [DATA_W-1:0] io_data_o,
  output logic              io_last_o,
  output logic              msg_valid_o,
  input  logic              msg_ready_i,
  output logic [DATA_W-1:0] msg_data_o,
  output logic              msg_last_o,
  output logic              mnt_valid_o,
  input  logic              mnt_ready_i,
  output logic [DATA_W-1:0] mnt_data_o,
  output logic              mnt_last_o,
  output logic              usr_valid_o,
  input  logic              usr_ready_i,
  output logic [DATA_W-1:0] usr_data_o,
  output logic              usr_last_o,
  output logic              decode_err_o
);
  logic [FT_W-1:0]    ftype;
  dst_e               dst_new, dst_sel;
  logic               mid, fire;
  logic [NUM_DST-1:0] out_valid, out_ready;

  assign ftype = s_data_i[FT_LSB +: FT_W];

  ipr_classify u_classify (
    .ftype_i     (ftype),
    .msg_split_i (msg_split_i),
    .usr_en_i    (usr_en_i),
    .dst_o       (dst_new)
  );

  ipr_track u_track (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .fire_i (fire),
    .last_i (s_last_i),
    .dst_i  (dst_new),
    .dst_o  (dst_sel),
    .mid_o  (mid)
  );

  assign out_ready = {usr_ready_i, mnt_ready_i, msg_ready_i, io_ready_i};

  ipr_steer #(.N(NUM_DST)) u_steer (
    .in_valid_i  (s_valid_i),
    .sel_i       (dst_sel),
    .out_ready_i (out_ready),
    .out_valid_o (out_valid),
    .in_ready_o  (s_ready_o)
  );

  assign fire = s_valid_i && s_ready_o;

  ipr_err_flag u_err (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .first_fire_i (fire && !mid),
    .dropped_i    (dst_sel == DST_DROP),
    .err_o        (decode_err_o)
  );

  assign {usr_valid_o, mnt_valid_o, msg_valid_o, io_valid_o} = out_valid;
  assign io_data_o  = s_data_i;
  assign msg_data_o = s_data_i;
  assign mnt_data_o = s_data_i;
  assign usr_data_o = s_data_i;
  assign io_last_o  = s_last_i;
  assign msg_last_o = s_last_i;
  assign mnt_last_o = s_last_i;
  assign usr_last_o = s_last_i;

  AST_ONE_DEST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(out_valid)); // R4

  AST_MNT_PATH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && !mid && ftype == FT_MNT) |-> mnt_valid_o); // R4

  AST_MSG_SPLIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && !mid && ftype == FT_MSG && msg_split_i) |-> msg_valid_o); // R3

  AST_DROP_FULL_RATE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (s_valid_i && out_valid == '0) |-> s_ready_o); // R6

  AST_ERR_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && out_valid == '0) |=> decode_err_o); // R7

  AST_ERR_CLR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (fire && !mid && out_valid != '0) |=> !decode_err_o); // R7

  AST_BACKPRESSURE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (out_valid != '0 && s_ready_o) |-> ((out_valid & out_ready) != '0)); // R9

  for (genvar k = 0; k < NUM_DST; k++) begin : g_chk
    AST_KEEP_PORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (out_valid[k] && out_ready[k] && !s_last_i) |=> (!s_valid_i || out_valid[k])); // R8
  end
endmodule

// File: tb/inb_port_router_tb.sv
module inb_port_router_tb;
  localparam int DW = 64;

  logic clk = 1'b0;
  always #5 clk = ~clk;

  logic rst_n, split, usren;
  logic s_valid, s_ready, s_last;
  logic [DW-1:0] s_data;
  logic io_v, io_r, io_l, msg_v, msg_r, msg_l, mnt_v, mnt_r, mnt_l, usr_v, usr_r, usr_l;
  logic [DW-1:0] io_d, msg_d, mnt_d, usr_d;
  logic derr;

  int n_chk = 0;
  int n_fail = 0;

  inb_port_router u_dut (
    .clk_i(clk), .rst_ni(rst_n), .msg_split_i(split), .usr_en_i(usren),
    .s_valid_i(s_valid), .s_ready_o(s_ready), .s_data_i(s_data), .s_last_i(s_last),
    .io_valid_o(io_v), .io_ready_i(io_r), .io_data_o(io_d), .io_last_o(io_l),
    .msg_valid_o(msg_v), .msg_ready_i(msg_r), .msg_data_o(msg_d), .msg_last_o(msg_l),
    .mnt_valid_o(mnt_v), .mnt_ready_i(mnt_r), .mnt_data_o(mnt_d), .mnt_last_o(mnt_l),
    .usr_valid_o(usr_v), .usr_ready_i(usr_r), .usr_data_o(usr_d), .usr_last_o(usr_l),
    .decode_err_o(derr)
  );

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  // 0 io, 1 msg, 2 mnt, 3 usr, 4 drop
  function automatic int exp_dst(input int ft, input bit sp, input bit ue);
    if (ft == 2 || ft == 5 || ft == 6 || ft == 13 || ft == 10) return 0;
    if (ft == 11) return sp ? 1 : 0;
    if (ft == 8) return 2;
    return ue ? 3 : 4;
  endfunction

  function automatic string req_of(input int ft, input bit ue);
    if (ft == 2 || ft == 5 || ft == 6 || ft == 13) return "R1";
    if (ft == 10) return "R2";
    if (ft == 11) return "R3";
    if (ft == 8) return "R4";
    return ue ? "R5" : "R6";
  endfunction

  function automatic logic [DW-1:0] mk_beat(input int ft, input int b);
    logic [DW-1:0] d;
    d = 64'h0123_4567_89AB_CDEF ^ (64'(b) * 64'h1111_1111_1111_1111);
    d[55:52] = 4'((ft + 3 * b) % 16);
    return d;
  endfunction

  task automatic set_ready(input logic v);
    io_r = v; msg_r = v; mnt_r = v; usr_r = v;
  endtask

  task automatic check_out(input int e, input string req);
    logic [3:0] vs, ev;
    logic [DW-1:0] d;
    logic l;
    vs = {usr_v, mnt_v, msg_v, io_v};
    ev = (e < 4) ? (4'b1 << e) : 4'b0;
    chk(vs == ev, req, "valid vector", DW'(vs), DW'(ev));
    if (e < 4) begin
      case (e)
        0: begin d = io_d;  l = io_l;  end
        1: begin d = msg_d; l = msg_l; end
        2: begin d = mnt_d; l = mnt_l; end
        default: begin d = usr_d; l = usr_l; end
      endcase
      chk(d == s_data && l == s_last, "R9", "data/last passthrough",
          {d[DW-2:0], l}, {s_data[DW-2:0], s_last});
    end
  endtask

  task automatic send_pkt(input int ft, input bit sp, input bit ue, input int nb);
    int e;
    string rq;
    e = exp_dst(ft, sp, ue);
    rq = req_of(ft, ue);
    @(negedge clk);
    split = sp; usren = ue;
    for (int b = 0; b < nb; b++) begin
      s_valid = 1'b1;
      s_data  = mk_beat(ft, b);
      s_last  = (b == nb - 1);
      if (b == 1) begin
        split = ~sp; usren = ~ue;  // R8: config flip mid-packet must not matter
      end
      #1;
      check_out(e, (b == 0) ? rq : "R8");
      chk(s_ready == 1'b1, (e == 4) ? "R6" : "R9", "ready with sinks ready", DW'(s_ready), 1);
      if (b == 1) begin
        set_ready(1'b0);
        #1;
        chk(s_ready == (e == 4), (e == 4) ? "R6" : "R9", "ready while sinks stalled",
            DW'(s_ready), DW'(e == 4));
        if (e != 4) begin
          @(posedge clk); @(negedge clk);
          check_out(e, "R8");
          set_ready(1'b1);
          #1;
        end
      end
      @(posedge clk);
      @(negedge clk);
      set_ready(1'b1);
    end
    s_valid = 1'b0; s_last = 1'b0; split = sp; usren = ue;
    #1;
    chk(derr == (e == 4), "R7", "decode error after packet", DW'(derr), DW'(e == 4));
  endtask

  initial begin
    rst_n = 1'b0; split = 1'b0; usren = 1'b0;
    s_valid = 1'b0; s_last = 1'b0; s_data = '0;
    set_ready(1'b1);
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(derr == 1'b0, "R10", "flag in reset", DW'(derr), 0);
    chk({usr_v, mnt_v, msg_v, io_v} == 4'b0, "R10", "valids in reset",
        DW'({usr_v, mnt_v, msg_v, io_v}), 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(derr == 1'b0, "R10", "flag after reset", DW'(derr), 0);

    for (int sp = 0; sp < 2; sp++)
      for (int ue = 0; ue < 2; ue++)
        for (int ft = 0; ft < 16; ft++)
          send_pkt(ft, sp[0], ue[0], 3);

    for (int ft = 0; ft < 16; ft++)
      send_pkt(ft, 1'b1, 1'b0, 1);

    // R7: flag persists through idle and clears on next routed packet
    send_pkt(7, 1'b0, 1'b0, 2);
    repeat (5) @(negedge clk);
    chk(derr == 1'b1, "R7", "flag held over idle", DW'(derr), 1);
    send_pkt(8, 1'b0, 1'b0, 2);
    chk(derr == 1'b0, "R7", "flag cleared by maintenance packet", DW'(derr), 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule